// File: doc/BRIEF.md
# Four-Channel Reloadable Memory Copy Engine

This block moves data between two address ranges on a simple single-beat memory bus, on behalf of four independent channels. Each channel holds a programmed source, destination and control word. It also keeps working copies of the remaining count and of the current source and destination addresses, and an on/off register. A channel that is switched on copies its programmed values into the working copies. It then waits for a trigger, which is either immediate when software triggering is selected, or a pulse on one of two hardware request lines: one from an audio serial port and one from a timer.

A triggered channel copies its count of units, each 1, 2 or 4 bytes, as a bus read followed by a bus write. The channels that are running share the bus one unit at a time in round-robin order. When the count is used up, the channel either reloads its working copies and stays on, or switches itself off. It can also pulse its interrupt line.

Top module: `dma4_engine`

## Requirements
- R1: After reset, mem_req and mem_we are low, irq is all zero and every channel is off.
- R2: Register select codes are 0 source, 1 destination, 2 control and 3 on/off. Source and destination addresses sit in bits 28:0, and bit 29 of either register holds that address fixed. In the control word, bits 19:0 hold the count, 21:20 the size code (0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes, shown on mem_size as 0, 1, 2, 2), 22 disables reload, 23 selects hardware triggering, 25:24 pick the hardware source and 28 enables the interrupt. Bit 1 of the on/off register switches the channel on.
- R3: A change of the on bit from 0 to 1 loads the working count and addresses from the programmed registers. If software triggering is selected, the copy starts at once, and a hardware-triggered channel waits. Later writes to the programmed registers do not alter a run whose working copies are already loaded.
- R4: Each unit is a read of the current source followed by a write of the data read to the current destination. After each unit, a non-fixed address advances by the unit size, modulo 2^29.
- R5: An audio request pulse triggers only channel 2, and only when that channel is on, hardware-triggered and has source code 0.
- R6: A timer request pulse triggers, all at once, every channel except channel 1 that is on, hardware-triggered and has source code 3. Other source codes are not triggered.
- R7: Running channels take the bus in turn one unit at a time, so two concurrent channels alternate.
- R8: At terminal count with reload enabled, the working copies reload from the programmed registers, which may have been rewritten meanwhile. The channel stays on and can be triggered again.
- R9: At terminal count with reload disabled, the channel switches itself off and ignores requests until it is switched on again.
- R10: At terminal count, irq[ch] pulses high for exactly one cycle if interrupt enable is set, and stays low otherwise.
- R11: A trigger with a zero count ends the run at once, with no bus traffic, following R8 to R10.
- R12: Clearing the on bit cancels a waiting trigger, and requests to an off channel are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_sel | input | 2 | Register select (R2) |
| cfg_wdata | input | 32 | Register write data |
| audio_req | input | 1 | Audio port request pulse |
| timer_req | input | 1 | Timer request pulse |
| mem_req | output | 1 | Bus request, held until mem_ack |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 29 | Byte address |
| mem_size | output | 2 | Transfer size code |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Completes the current beat |
| irq | output | 4 | Per-channel completion pulse |

## Verification
The bench builds the engine with its default parameters: four channels, a 29-bit address, a 20-bit count, the audio request on channel 2 and the timer excluded from channel 1. Four channels are enough to run two timer-triggered channels side by side while a third, excluded one is also armed, which exposes both the alternation and the exclusion. The 29-bit address lets a source run cross the top of the address space and wrap to zero.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    localparam int REG_W = 32;

    localparam logic [1:0] SEL_SRC  = 2'd0;
    localparam logic [1:0] SEL_DST  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_ONOFF = 2'd3;

    localparam int ADR_FIX_BIT  = 29;
    localparam int CTL_SIZE_LO  = 20;
    localparam int CTL_NORELOAD = 22;
    localparam int CTL_HWTRIG   = 23;
    localparam int CTL_HWSRC_LO = 24;
    localparam int CTL_IRQ_EN   = 28;
    localparam int ONOFF_BIT    = 1;

    localparam logic [1:0] HWSRC_AUDIO = 2'd0;
    localparam logic [1:0] HWSRC_TIMER = 2'd3;

    typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_e;

    // Size code 3 behaves as a word transfer.
    function automatic logic [1:0] size_clamp(input logic [1:0] code);
        return (code == 2'd3) ? 2'd2 : code;
    endfunction

    function automatic logic [2:0] unit_bytes(input logic [1:0] code);
        return 3'd1 << size_clamp(code);
    endfunction
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan
    import dma4_pkg::*;
#(
    parameter int ADDR_W        = 29,
    parameter int CNT_W         = 20,
    parameter int CH_ID         = 0,
    parameter int AUDIO_CH      = 2,
    parameter int TIMER_SKIP_CH = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              audio_req,
    input  logic              timer_req,
    input  logic              unit_done,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] cur_src,
    output logic [ADDR_W-1:0] cur_dst,
    output logic [1:0]        size_code,
    output logic              irq
);
    localparam bit AUDIO_OK = (CH_ID == AUDIO_CH);
    localparam bit TIMER_OK = (CH_ID != TIMER_SKIP_CH);

    typedef struct packed {
        logic [REG_W-1:0]  src_reg;
        logic [REG_W-1:0]  dst_reg;
        logic [REG_W-1:0]  ctrl_reg;
        logic              on;
        logic              pend;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] csrc;
        logic [ADDR_W-1:0] cdst;
        logic              irq;
    } chan_s;

    chan_s s_q, s_d;
    logic [ADDR_W-1:0] step;
    logic [1:0]        hw_src;
    logic              hw_hit;
    logic              terminal;

    always_comb begin
        s_d      = s_q;
        s_d.irq  = 1'b0;
        terminal = 1'b0;
        step     = ADDR_W'(unit_bytes(s_q.ctrl_reg[CTL_SIZE_LO +: 2]));
        hw_src   = s_q.ctrl_reg[CTL_HWSRC_LO +: 2];
        hw_hit   = s_q.ctrl_reg[CTL_HWTRIG] &&
                   ((AUDIO_OK && audio_req && hw_src == HWSRC_AUDIO) ||
                    (TIMER_OK && timer_req && hw_src == HWSRC_TIMER));

        if (s_q.on && !s_q.pend && hw_hit) begin
            s_d.pend = 1'b1;
        end

        if (s_q.on && s_q.pend) begin
            if (s_q.cnt == '0) begin
                terminal = 1'b1;
            end else if (unit_done) begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
                if (!s_q.src_reg[ADR_FIX_BIT]) s_d.csrc = s_q.csrc + step;
                if (!s_q.dst_reg[ADR_FIX_BIT]) s_d.cdst = s_q.cdst + step;
                if (s_q.cnt == CNT_W'(1)) terminal = 1'b1;
            end
        end

        if (terminal) begin
            s_d.pend = 1'b0;
            s_d.irq  = s_q.ctrl_reg[CTL_IRQ_EN];
            if (!s_q.ctrl_reg[CTL_NORELOAD]) begin
                s_d.cnt  = s_q.ctrl_reg[CNT_W-1:0];
                s_d.csrc = s_q.src_reg[ADDR_W-1:0];
                s_d.cdst = s_q.dst_reg[ADDR_W-1:0];
            end else begin
                s_d.on = 1'b0;
            end
        end

        if (wr_en) begin
            case (wr_sel)
                SEL_SRC:  s_d.src_reg  = wr_data;
                SEL_DST:  s_d.dst_reg  = wr_data;
                SEL_CTRL: s_d.ctrl_reg = wr_data;
                default: begin
                    if (wr_data[ONOFF_BIT] != s_q.on) begin
                        s_d.on = wr_data[ONOFF_BIT];
                        if (wr_data[ONOFF_BIT]) begin
                            s_d.cnt  = s_q.ctrl_reg[CNT_W-1:0];
                            s_d.csrc = s_q.src_reg[ADDR_W-1:0];
                            s_d.cdst = s_q.dst_reg[ADDR_W-1:0];
                            s_d.pend = !s_q.ctrl_reg[CTL_HWTRIG];
                        end else begin
                            s_d.pend = 1'b0;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign xfer_req  = s_q.on && s_q.pend && (s_q.cnt != '0);
    assign cur_src   = s_q.csrc;
    assign cur_dst   = s_q.cdst;
    assign size_code = size_clamp(s_q.ctrl_reg[CTL_SIZE_LO +: 2]);
    assign irq       = s_q.irq;

    // R10: the completion pulse lasts one cycle
    a_r10_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: a channel only switches itself off when reload is disabled
    a_r9_self_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(s_q.on) && !$past(wr_en)) |-> $past(s_q.ctrl_reg[CTL_NORELOAD]));

    // R11: an armed channel with an empty count finishes on the next edge
    a_r11_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.on && s_q.pend && s_q.cnt == '0) |=> !s_q.pend);
endmodule

// File: rtl/dma4_rr_arb.sv
module dma4_rr_arb #(
    parameter int N     = 4,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req,
    input  logic             take,
    output logic             grant_vld,
    output logic [IDX_W-1:0] grant_idx
);
    logic [IDX_W-1:0] last_q, last_d;

    always_comb begin
        grant_vld = 1'b0;
        grant_idx = '0;
        for (int k = 1; k <= N; k++) begin
            if (!grant_vld && req[(int'(last_q) + k) % N]) begin
                grant_vld = 1'b1;
                grant_idx = IDX_W'((int'(last_q) + k) % N);
            end
        end
        last_d = (take && grant_vld) ? grant_idx : last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= IDX_W'(N - 1);
        else        last_q <= last_d;
    end
endmodule

// File: rtl/dma4_mover.sv
module dma4_mover
    import dma4_pkg::*;
#(
    parameter int N      = 4,
    parameter int IDX_W  = 2,
    parameter int ADDR_W = 29,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grant_vld,
    input  logic [IDX_W-1:0]  grant_idx,
    input  logic [ADDR_W-1:0] sel_src,
    input  logic [ADDR_W-1:0] sel_dst,
    input  logic [1:0]        sel_size,
    output logic              take,
    output logic              done,
    output logic [IDX_W-1:0]  done_idx,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    typedef struct packed {
        mv_state_e         st;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [1:0]        size;
        logic [DATA_W-1:0] data;
    } mv_s;

    mv_s s_q, s_d;

    always_comb begin
        s_d  = s_q;
        take = 1'b0;
        done = 1'b0;
        case (s_q.st)
            MV_IDLE: begin
                if (grant_vld) begin
                    take     = 1'b1;
                    s_d.idx  = grant_idx;
                    s_d.src  = sel_src;
                    s_d.dst  = sel_dst;
                    s_d.size = sel_size;
                    s_d.st   = MV_READ;
                end
            end
            MV_READ: begin
                if (mem_ack) begin
                    s_d.data = mem_rdata;
                    s_d.st   = MV_WRITE;
                end
            end
            default: begin
                if (mem_ack) begin
                    done   = 1'b1;
                    s_d.st = MV_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mem_req   = (s_q.st != MV_IDLE);
    assign mem_we    = (s_q.st == MV_WRITE);
    assign mem_addr  = mem_we ? s_q.dst : s_q.src;
    assign mem_size  = s_q.size;
    assign mem_wdata = s_q.data;
    assign done_idx  = s_q.idx;

    // R4: a beat holds its request until acknowledged
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R4: an acknowledged read is followed by the write of the same unit
    a_r4_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

    // R4: the bus is released after the write of a unit
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && mem_ack) |=> !mem_req);
endmodule

// File: rtl/dma4_engine.sv
module dma4_engine
    import dma4_pkg::*;
#(
    parameter int NUM_CH        = 4,
    parameter int ADDR_W        = 29,
    parameter int CNT_W         = 20,
    parameter int DATA_W        = 32,
    parameter int AUDIO_CH      = 2,
    parameter int TIMER_SKIP_CH = 1,
    localparam int CH_W         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_ch,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              audio_req,
    input  logic              timer_req,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack,
    output logic [NUM_CH-1:0] irq
);
    logic [NUM_CH-1:0] ch_req;
    logic [ADDR_W-1:0] ch_src  [NUM_CH];
    logic [ADDR_W-1:0] ch_dst  [NUM_CH];
    logic [1:0]        ch_size [NUM_CH];
    logic              grant_vld, take, done;
    logic [CH_W-1:0]   grant_idx, done_idx;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma4_chan #(
            .ADDR_W(ADDR_W), .CNT_W(CNT_W), .CH_ID(c),
            .AUDIO_CH(AUDIO_CH), .TIMER_SKIP_CH(TIMER_SKIP_CH)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (cfg_we && (cfg_ch == CH_W'(c))),
            .wr_sel    (cfg_sel),
            .wr_data   (cfg_wdata),
            .audio_req (audio_req),
            .timer_req (timer_req),
            .unit_done (done && (done_idx == CH_W'(c))),
            .xfer_req  (ch_req[c]),
            .cur_src   (ch_src[c]),
            .cur_dst   (ch_dst[c]),
            .size_code (ch_size[c]),
            .irq       (irq[c])
        );
    end

    dma4_rr_arb #(.N(NUM_CH), .IDX_W(CH_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (ch_req),
        .take      (take),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx)
    );

    dma4_mover #(.N(NUM_CH), .IDX_W(CH_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .grant_vld (grant_vld),
        .grant_idx (grant_idx),
        .sel_src   (ch_src[grant_idx]),
        .sel_dst   (ch_dst[grant_idx]),
        .sel_size  (ch_size[grant_idx]),
        .take      (take),
        .done      (done),
        .done_idx  (done_idx),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack)
    );
endmodule

// File: tb/dma4_engine_test.sv
module dma4_engine_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [1:0]  cfg_sel = '0;
    logic [31:0] cfg_wdata = '0;
    logic        audio_req = 1'b0;
    logic        timer_req = 1'b0;
    logic        mem_req, mem_we;
    logic [28:0] mem_addr;
    logic [1:0]  mem_size;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic [3:0]  irq;

    always #5 clk = ~clk;

    dma4_engine uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .audio_req(audio_req), .timer_req(timer_req),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack), .irq(irq)
    );

    typedef struct {
        int          ch;
        logic [28:0] addr;
        logic [31:0] data;
        logic [1:0]  size;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    int   irq_seen [4];
    int   irq_exp  [4];
    int   wlog [64];
    int   log_n = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pattern(input logic [28:0] a);
        return {3'b101, a};
    endfunction

    function automatic logic [31:0] mk_ctrl(input int cnt, input int code, input bit norl,
                                            input bit hw, input int hsrc, input bit ien);
        logic [31:0] v;
        v = '0;
        v[19:0]  = 20'(cnt);
        v[21:20] = 2'(code);
        v[22]    = norl;
        v[23]    = hw;
        v[25:24] = 2'(hsrc);
        v[28]    = ien;
        return v;
    endfunction

    // Memory model and scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && mem_req && mem_we) begin
            int c;
            int hit;
            c = int'(mem_addr >> 20) - 1;
            hit = -1;
            foreach (exp_q[i]) if (hit < 0 && exp_q[i].ch == c) hit = i;
            if (hit < 0) begin
                check(1'b0, "R3/R5/R6/R9/R12 unexpected write", longint'(mem_addr), 0);
            end else begin
                check(mem_addr == exp_q[hit].addr && mem_wdata == exp_q[hit].data &&
                      mem_size == exp_q[hit].size, exp_q[hit].tag,
                      {mem_size, mem_addr, mem_wdata},
                      {exp_q[hit].size, exp_q[hit].addr, exp_q[hit].data});
                exp_q.delete(hit);
            end
            if (log_n < 64) begin
                wlog[log_n] = c;
                log_n++;
            end
        end
        for (int c = 0; c < 4; c++) if (rst_n && irq[c]) irq_seen[c]++;
        mem_ack   = rst_n && mem_req;
        mem_rdata = pattern(mem_addr);
    end

    task automatic cfg(input int ch, input int sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_sel = 2'(sel); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic pulse_timer();
        @(negedge clk); timer_req = 1'b1;
        @(negedge clk); timer_req = 1'b0;
    endtask

    task automatic pulse_audio();
        @(negedge clk); audio_req = 1'b1;
        @(negedge clk); audio_req = 1'b0;
    endtask

    task automatic push_run(input int ch, input logic [28:0] src, input logic [28:0] dst,
                            input int n, input int code, input bit sfix, input bit dfix,
                            input string tag);
        logic [28:0] s, d;
        logic [1:0]  sz;
        exp_t e;
        s = src; d = dst;
        sz = (code == 3) ? 2'd2 : 2'(code);
        for (int k = 0; k < n; k++) begin
            e.ch = ch; e.addr = d; e.data = pattern(s); e.size = sz; e.tag = tag;
            exp_q.push_back(e);
            if (!sfix) s = s + (29'd1 << sz);
            if (!dfix) d = d + (29'd1 << sz);
        end
    endtask

    task automatic drain(input string tag);
        int t;
        t = 0;
        while (exp_q.size() != 0 && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (6) @(negedge clk);
        check(exp_q.size() == 0, tag, exp_q.size(), 0);
    endtask

    task automatic quiet();
        repeat (20) @(negedge clk);
    endtask

    function automatic logic [31:0] fixed_adr(input logic [28:0] a);
        return {2'b00, 1'b1, a};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 4; c++) begin irq_seen[c] = 0; irq_exp[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        check(mem_req == 1'b0 && mem_we == 1'b0, "R1 bus idle", {mem_req, mem_we}, 0);
        check(irq == 4'b0, "R1 irq low", irq, 0);

        // R2/R4/R10: software trigger, words, both addresses increment
        cfg(0, 0, 32'h0000_1000);
        cfg(0, 1, 32'h0010_0000);
        cfg(0, 2, mk_ctrl(4, 2, 0, 0, 0, 1));
        push_run(0, 29'h1000, 29'h10_0000, 4, 2, 0, 0, "R4 word incrementing copy");
        irq_exp[0]++;
        cfg(0, 3, 32'h2);
        drain("R3 software run completes");
        check(irq_seen[0] == irq_exp[0], "R10 irq on completion", irq_seen[0], irq_exp[0]);
        cfg(0, 3, 32'h0);

        // R2/R4/R10: bytes, fixed destination, no interrupt
        cfg(1, 0, 32'h0000_2000);
        cfg(1, 1, fixed_adr(29'h20_0040));
        cfg(1, 2, mk_ctrl(5, 0, 0, 0, 0, 0));
        push_run(1, 29'h2000, 29'h20_0040, 5, 0, 0, 1, "R4 byte copy fixed destination");
        cfg(1, 3, 32'h2);
        drain("R4 byte run completes");
        check(irq_seen[1] == 0, "R10 no irq when disabled", irq_seen[1], 0);
        cfg(1, 3, 32'h0);

        // R2/R4: halfwords with fixed source, size code 3 as words
        cfg(2, 0, fixed_adr(29'h3000));
        cfg(2, 1, 32'h0030_0000);
        cfg(2, 2, mk_ctrl(3, 1, 0, 0, 0, 0));
        push_run(2, 29'h3000, 29'h30_0000, 3, 1, 1, 0, "R4 halfword copy fixed source");
        cfg(2, 3, 32'h2);
        drain("R4 halfword run completes");
        cfg(2, 3, 32'h0);
        cfg(3, 0, 32'h0000_4000);
        cfg(3, 1, 32'h0040_0000);
        cfg(3, 2, mk_ctrl(2, 3, 0, 0, 0, 0));
        push_run(3, 29'h4000, 29'h40_0000, 2, 3, 0, 0, "R2 size code 3 moves words");
        cfg(3, 3, 32'h2);
        drain("R2 size code 3 run completes");
        cfg(3, 3, 32'h0);

        // R4: source address wraps at the top of the space
        cfg(0, 0, 32'h1FFF_FFF8);
        cfg(0, 1, 32'h0010_0100);
        cfg(0, 2, mk_ctrl(4, 2, 0, 0, 0, 0));
        push_run(0, 29'h1FFF_FFF8, 29'h10_0100, 4, 2, 0, 0, "R4 source address wrap");
        cfg(0, 3, 32'h2);
        drain("R4 wrap run completes");
        cfg(0, 3, 32'h0);

        // R11: zero count ends at once with an interrupt and no traffic
        cfg(1, 0, 32'h0000_2100);
        cfg(1, 1, 32'h0020_0100);
        cfg(1, 2, mk_ctrl(0, 2, 0, 0, 0, 1));
        irq_exp[1]++;
        cfg(1, 3, 32'h2);
        quiet();
        check(irq_seen[1] == irq_exp[1], "R11 zero count irq", irq_seen[1], irq_exp[1]);
        cfg(1, 3, 32'h0);

        // R5: audio request reaches only channel 2 with source 0
        cfg(2, 0, 32'h0000_5000);
        cfg(2, 1, 32'h0030_0100);
        cfg(2, 2, mk_ctrl(2, 2, 0, 1, 0, 1));
        cfg(0, 0, 32'h0000_6000);
        cfg(0, 1, 32'h0010_0200);
        cfg(0, 2, mk_ctrl(1, 2, 0, 1, 0, 0));
        cfg(2, 3, 32'h2);
        cfg(0, 3, 32'h2);
        quiet();
        pulse_timer();
        quiet();
        push_run(2, 29'h5000, 29'h30_0100, 2, 2, 0, 0, "R5 audio request on channel 2");
        irq_exp[2]++;
        pulse_audio();
        drain("R5 audio run completes");
        check(irq_seen[2] == irq_exp[2], "R5 audio run irq", irq_seen[2], irq_exp[2]);
        cfg(2, 3, 32'h0);
        cfg(0, 3, 32'h0);

        // R6/R7: one timer pulse fires channels 0 and 3, not 1 or mismatched 2
        cfg(0, 0, 32'h0000_7000);
        cfg(0, 1, 32'h0010_0300);
        cfg(0, 2, mk_ctrl(4, 2, 0, 1, 3, 0));
        cfg(3, 0, 32'h0000_8000);
        cfg(3, 1, 32'h0040_0300);
        cfg(3, 2, mk_ctrl(4, 2, 0, 1, 3, 0));
        cfg(1, 0, 32'h0000_9000);
        cfg(1, 1, 32'h0020_0300);
        cfg(1, 2, mk_ctrl(2, 2, 0, 1, 3, 0));
        cfg(2, 0, 32'h0000_9100);
        cfg(2, 1, 32'h0030_0300);
        cfg(2, 2, mk_ctrl(1, 2, 0, 1, 1, 0));
        for (int c = 0; c < 4; c++) cfg(c, 3, 32'h2);
        push_run(0, 29'h7000, 29'h10_0300, 4, 2, 0, 0, "R6 timer fires channel 0");
        push_run(3, 29'h8000, 29'h40_0300, 4, 2, 0, 0, "R6 timer fires channel 3");
        log_n = 0;
        pulse_timer();
        drain("R6 timer runs complete");
        quiet();
        check(log_n == 8, "R6 only channels 0 and 3 moved", log_n, 8);
        for (int i = 1; i < 8; i++)
            check(wlog[i] != wlog[i-1], "R7 round-robin alternation", wlog[i], wlog[i-1]);
        for (int c = 0; c < 4; c++) cfg(c, 3, 32'h0);

        // R3/R8: a rewrite during a loaded run is picked up only by the reload
        cfg(0, 0, 32'h0000_A000);
        cfg(0, 1, 32'h0010_0400);
        cfg(0, 2, mk_ctrl(2, 2, 0, 1, 3, 1));
        cfg(0, 3, 32'h2);
        cfg(0, 0, 32'h0000_B000);
        push_run(0, 29'hA000, 29'h10_0400, 2, 2, 0, 0, "R3 loaded source kept");
        irq_exp[0]++;
        pulse_timer();
        drain("R3 first timer run completes");
        push_run(0, 29'hB000, 29'h10_0400, 2, 2, 0, 0, "R8 reload takes new source");
        irq_exp[0]++;
        pulse_timer();
        drain("R8 reloaded run completes");
        check(irq_seen[0] == irq_exp[0], "R8 irq per reloaded run", irq_seen[0], irq_exp[0]);
        cfg(0, 3, 32'h0);

        // R9: reload disabled switches the channel off
        cfg(3, 0, 32'h0000_C000);
        cfg(3, 1, 32'h0040_0500);
        cfg(3, 2, mk_ctrl(1, 2, 1, 1, 3, 1));
        cfg(3, 3, 32'h2);
        push_run(3, 29'hC000, 29'h40_0500, 1, 2, 0, 0, "R9 single run");
        irq_exp[3]++;
        pulse_timer();
        drain("R9 run completes");
        pulse_timer();
        quiet();
        cfg(3, 3, 32'h2);
        quiet();
        push_run(3, 29'hC000, 29'h40_0500, 1, 2, 0, 0, "R9 run after switching on again");
        irq_exp[3]++;
        pulse_timer();
        drain("R9 restarted run completes");
        cfg(3, 3, 32'h0);

        // R12: switching off makes requests ineffective
        cfg(0, 0, 32'h0000_D000);
        cfg(0, 1, 32'h0010_0600);
        cfg(0, 2, mk_ctrl(1, 2, 0, 1, 3, 1));
        cfg(0, 3, 32'h2);
        cfg(0, 3, 32'h0);
        pulse_timer();
        quiet();
        check(irq_seen[0] == irq_exp[0], "R12 off channel stays silent", irq_seen[0], irq_exp[0]);

        check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 0);
        for (int c = 0; c < 4; c++)
            check(irq_seen[c] == irq_exp[c], "R10 irq total", irq_seen[c], irq_exp[c]);

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule